// File: doc/BRIEF.md
# Dual amplifier channel control register file and switch decoder

This block holds the programmable state of two analog amplifier channels and turns it into the static control lines of the analog macro. Software writes and reads three 32-bit words per channel over a simple single-cycle register port: one control word and two offset-trim words. One trim word is for normal operation and one is for low-power operation. The block decodes the control word into several lines: the noninverting and inverting input switches, the follower feedback switch, a one-hot gain tap, the output driver enable and the calibration isolate line. It also chooses which 10-bit trim code reaches the analog core, from three sources: the factory code, the user normal-mode word or the user low-power word.

Factory trim codes arrive as constant input ports, and the trim words load them at reset. The comparator result of each channel's calibration loop arrives asynchronously. It passes through a two-flop synchronizer and is readable in the control word only while calibration is on. The low-power bit of a channel is locked while that channel is enabled. Reads are combinational on the address, and writes take effect at the clock edge that samples `wr_en`.

Top module: `amp_ctrl_regs`

## Requirements
- R1: After reset both control words read 0. Each trim word reads its factory input, with the N-pair code in bits 4:0 and the P-pair code in bits 12:8. The applied trim equals the factory normal-mode code.
- R2: The writable control bits are: enable at bit 0, low-power at 1, mode at 3:2, gain at 5:4, inverting select at 9, noninverting select at 10, calibration on at 12, calibration pair at 13, user trim at 14 and high-speed at 30. Every other bit reads 0. Bit 31 exists only in channel 1's word at offset 0x00 and drives `range_en`, which is shared by both channels. `lp_en` and `hs_en` follow bits 1 and 30.
- R3: Channel 1 uses byte offsets 0x00 (control), 0x04 (normal trim) and 0x08 (low-power trim); channel 2 uses 0x10, 0x14 and 0x18. Any other address reads 0, and a write to it changes nothing.
- R4: `out_en` is high only when the enable bit is 1 and the calibration bit is 0. It is low whenever the enable bit is 0.
- R5: With the channel enabled and not calibrating, noninverting select 0 closes `vinp_pin_sw` and 1 closes `vinp_dac_sw`. Both are open otherwise.
- R6: With the channel enabled and not calibrating, `vinm_pin_sw` closes when bit 9 is 0 and the mode is 00, 01 or 10. Mode 11 (follower) closes `follow_sw`, keeps `vinm_pin_sw` open and ignores bit 9.
- R7: In mode 10, with the channel enabled and not calibrating, `pga_tap` bit k of the channel (gain code k: x2, x4, x8, x16 for k = 0 to 3) is the only tap set. In every other case all taps are 0.
- R8: With both enable and calibration set, `cal_iso` is 1 and every input, feedback and output switch is open. `cal_psel` follows bit 13 (0 selects the N pair, 1 selects the P pair).
- R9: With user trim 0, the applied trim is the factory normal code when low-power is 0 and the factory low-power code when it is 1. With user trim 1, it is the matching user trim word, whatever the enable bit.
- R10: While the stored enable bit is 1, a control write keeps the old low-power bit and applies all other fields. This holds even for a write that clears enable. Trim words and configuration are retained while a channel is disabled.
- R11: Bit 15 reads the comparator input after two clock edges of synchronization while calibration is on. It reads 0 while calibration is off and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte address of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| fact_trim_nrm | input | NCH*10 | Factory normal-mode trim per channel, {P,N} |
| fact_trim_lp | input | NCH*10 | Factory low-power trim per channel, {P,N} |
| cmp_async | input | NCH | Asynchronous calibration comparator per channel |
| vinp_pin_sw | output | NCH | Noninverting input to pin switch |
| vinp_dac_sw | output | NCH | Noninverting input to DAC switch |
| vinm_pin_sw | output | NCH | Inverting input to pin switch |
| follow_sw | output | NCH | Output-to-inverting-input follower switch |
| pga_tap | output | NCH*4 | One-hot gain tap per channel (x2,x4,x8,x16) |
| out_en | output | NCH | Output driver enable (0 = high impedance) |
| cal_iso | output | NCH | Calibration isolation active |
| cal_psel | output | NCH | Calibration pair select (1 = P pair) |
| lp_en | output | NCH | Low-power mode |
| hs_en | output | NCH | High-speed mode |
| range_en | output | 1 | Global range setting |
| trim_n_out | output | NCH*5 | Applied N-pair trim code per channel |
| trim_p_out | output | NCH*5 | Applied P-pair trim code per channel |

## Verification
Two functions meet in the cycle in which a control write arrives at an enabled channel. The same edge must apply the new mode, select and enable fields while it keeps the locked low-power bit. The bench provokes this with writes that change the low-power bit together with the mode or the enable bit while the channel is on. It then reads the word back and checks `lp_en` and the decoded switches: the low-power bit must be the old one and every other field the new one. A second overlap comes from a comparator edge while calibration is being switched off. Bit 15 must then read 0 even though the synchronized comparator is high.

// File: rtl/amp_pkg.sv
package amp_pkg;

    localparam int DATA_W  = 32;
    localparam int TRIM_W  = 5;
    localparam int TRIM2_W = 2 * TRIM_W;
    localparam int TRIM_P_LSB = 8;
    localparam int NTAP    = 4;

    typedef enum logic [1:0] {
        MODE_EXT_A  = 2'b00,
        MODE_EXT_B  = 2'b01,
        MODE_PGA    = 2'b10,
        MODE_FOLLOW = 2'b11
    } mode_e;

    typedef struct packed {
        logic       range;
        logic       hs;
        logic       usr;
        logic       calsel;
        logic       calon;
        logic       vp;
        logic       vm;
        logic [1:0] gain;
        logic [1:0] mode;
        logic       lp;
        logic       en;
    } csr_t;

    typedef struct packed {
        logic              vinp_pin;
        logic              vinp_dac;
        logic              vinm_pin;
        logic              follow;
        logic [NTAP-1:0]   tap;
        logic              out_en;
        logic              cal_iso;
    } route_t;

    function automatic csr_t csr_unpack(input logic [DATA_W-1:0] w, input logic allow_range);
        csr_t c;
        c.range  = allow_range & w[31];
        c.hs     = w[30];
        c.usr    = w[14];
        c.calsel = w[13];
        c.calon  = w[12];
        c.vp     = w[10];
        c.vm     = w[9];
        c.gain   = w[5:4];
        c.mode   = w[3:2];
        c.lp     = w[1];
        c.en     = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] csr_pack(input csr_t c, input logic calout);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[31]  = c.range;
        w[30]  = c.hs;
        w[15]  = calout;
        w[14]  = c.usr;
        w[13]  = c.calsel;
        w[12]  = c.calon;
        w[10]  = c.vp;
        w[9]   = c.vm;
        w[5:4] = c.gain;
        w[3:2] = c.mode;
        w[1]   = c.lp;
        w[0]   = c.en;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] trim_pack(input logic [TRIM2_W-1:0] t);
        logic [DATA_W-1:0] w;
        w = '0;
        w[TRIM_P_LSB +: TRIM_W] = t[TRIM2_W-1 -: TRIM_W];
        w[0 +: TRIM_W]          = t[TRIM_W-1:0];
        return w;
    endfunction

    function automatic logic [TRIM2_W-1:0] trim_unpack(input logic [DATA_W-1:0] w);
        return {w[TRIM_P_LSB +: TRIM_W], w[0 +: TRIM_W]};
    endfunction

endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/amp_chan_regs.sv
module amp_chan_regs
    import amp_pkg::*;
#(
    parameter bit HAS_RANGE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_csr,
    input  logic               wr_nrm,
    input  logic               wr_lp,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [TRIM2_W-1:0] fact_nrm,
    input  logic [TRIM2_W-1:0] fact_lp,
    output csr_t               csr_q,
    output logic [TRIM2_W-1:0] usr_nrm_q,
    output logic [TRIM2_W-1:0] usr_lp_q
);
    csr_t csr_nx;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[29:16], wdata[15], wdata[11], wdata[8:6]};

    always_comb begin
        csr_nx = csr_unpack(wdata, HAS_RANGE);
        if (csr_q.en) begin
            csr_nx.lp = csr_q.lp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q     <= '0;
            usr_nrm_q <= fact_nrm;
            usr_lp_q  <= fact_lp;
        end else begin
            if (wr_csr) csr_q     <= csr_nx;
            if (wr_nrm) usr_nrm_q <= trim_unpack(wdata);
            if (wr_lp)  usr_lp_q  <= trim_unpack(wdata);
        end
    end
endmodule

// File: rtl/amp_route_dec.sv
module amp_route_dec
    import amp_pkg::*;
(
    input  csr_t   csr,
    output route_t route
);
    logic  active;
    mode_e mode;

    assign active = csr.en & ~csr.calon;
    assign mode   = mode_e'(csr.mode);

    always_comb begin
        route          = '0;
        route.out_en   = active;
        route.cal_iso  = csr.en & csr.calon;
        route.vinp_pin = active & ~csr.vp;
        route.vinp_dac = active & csr.vp;
        route.follow   = active & (mode == MODE_FOLLOW);
        route.vinm_pin = active & (mode != MODE_FOLLOW) & ~csr.vm;
        if (active && mode == MODE_PGA) begin
            route.tap = NTAP'(1) << csr.gain;
        end
    end
endmodule

// File: rtl/amp_trim_sel.sv
module amp_trim_sel
    import amp_pkg::*;
(
    input  logic               use_user,
    input  logic               low_pwr,
    input  logic [TRIM2_W-1:0] usr_nrm,
    input  logic [TRIM2_W-1:0] usr_lp,
    input  logic [TRIM2_W-1:0] fact_nrm,
    input  logic [TRIM2_W-1:0] fact_lp,
    output logic [TRIM_W-1:0]  trim_n,
    output logic [TRIM_W-1:0]  trim_p
);
    logic [TRIM2_W-1:0] user_pick;
    logic [TRIM2_W-1:0] fact_pick;
    logic [TRIM2_W-1:0] applied;

    assign user_pick = low_pwr ? usr_lp  : usr_nrm;
    assign fact_pick = low_pwr ? fact_lp : fact_nrm;
    assign applied   = use_user ? user_pick : fact_pick;
    assign trim_n    = applied[TRIM_W-1:0];
    assign trim_p    = applied[TRIM2_W-1 -: TRIM_W];
endmodule

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs
    import amp_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic [NCH*TRIM2_W-1:0] fact_trim_nrm,
    input  logic [NCH*TRIM2_W-1:0] fact_trim_lp,
    input  logic [NCH-1:0]         cmp_async,
    output logic [NCH-1:0]         vinp_pin_sw,
    output logic [NCH-1:0]         vinp_dac_sw,
    output logic [NCH-1:0]         vinm_pin_sw,
    output logic [NCH-1:0]         follow_sw,
    output logic [NCH*NTAP-1:0]    pga_tap,
    output logic [NCH-1:0]         out_en,
    output logic [NCH-1:0]         cal_iso,
    output logic [NCH-1:0]         cal_psel,
    output logic [NCH-1:0]         lp_en,
    output logic [NCH-1:0]         hs_en,
    output logic                   range_en,
    output logic [NCH*TRIM_W-1:0]  trim_n_out,
    output logic [NCH*TRIM_W-1:0]  trim_p_out
);
    localparam int CH_W     = ADDR_W - 4;
    localparam int WORD_CSR = 0;
    localparam int WORD_NRM = 1;
    localparam int WORD_LP  = 2;

    logic [CH_W-1:0] a_ch;
    logic [1:0]      a_word;
    logic            a_ok;
    logic [NCH-1:0]  cmp_sync;
    logic [NCH-1:0]  chan_en;

    csr_t               csr_q   [NCH];
    logic [TRIM2_W-1:0] usr_nrm [NCH];
    logic [TRIM2_W-1:0] usr_lp  [NCH];
    logic [NCH-1:0]     calout;

    assign a_ch   = addr[ADDR_W-1:4];
    assign a_word = addr[3:2];
    assign a_ok   = (addr[1:0] == 2'b00) && (a_word != 2'd3) && (int'(a_ch) < NCH);

    amp_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (cmp_async),
        .q_sync  (cmp_sync)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic   sel;
        route_t route;

        assign sel = a_ok && (int'(a_ch) == ch) && wr_en;

        amp_chan_regs #(.HAS_RANGE(ch == 0)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .wr_csr    (sel && a_word == 2'(WORD_CSR)),
            .wr_nrm    (sel && a_word == 2'(WORD_NRM)),
            .wr_lp     (sel && a_word == 2'(WORD_LP)),
            .wdata     (wdata),
            .fact_nrm  (fact_trim_nrm[ch*TRIM2_W +: TRIM2_W]),
            .fact_lp   (fact_trim_lp[ch*TRIM2_W +: TRIM2_W]),
            .csr_q     (csr_q[ch]),
            .usr_nrm_q (usr_nrm[ch]),
            .usr_lp_q  (usr_lp[ch])
        );

        amp_route_dec u_dec (
            .csr   (csr_q[ch]),
            .route (route)
        );

        amp_trim_sel u_trim (
            .use_user (csr_q[ch].usr),
            .low_pwr  (csr_q[ch].lp),
            .usr_nrm  (usr_nrm[ch]),
            .usr_lp   (usr_lp[ch]),
            .fact_nrm (fact_trim_nrm[ch*TRIM2_W +: TRIM2_W]),
            .fact_lp  (fact_trim_lp[ch*TRIM2_W +: TRIM2_W]),
            .trim_n   (trim_n_out[ch*TRIM_W +: TRIM_W]),
            .trim_p   (trim_p_out[ch*TRIM_W +: TRIM_W])
        );

        assign calout[ch]                 = cmp_sync[ch] & csr_q[ch].calon;
        assign chan_en[ch]                = csr_q[ch].en;
        assign vinp_pin_sw[ch]            = route.vinp_pin;
        assign vinp_dac_sw[ch]            = route.vinp_dac;
        assign vinm_pin_sw[ch]            = route.vinm_pin;
        assign follow_sw[ch]              = route.follow;
        assign pga_tap[ch*NTAP +: NTAP]   = route.tap;
        assign out_en[ch]                 = route.out_en;
        assign cal_iso[ch]                = route.cal_iso;
        assign cal_psel[ch]               = csr_q[ch].calsel;
        assign lp_en[ch]                  = csr_q[ch].lp;
        assign hs_en[ch]                  = csr_q[ch].hs;
    end

    assign range_en = csr_q[0].range;

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (a_ok && int'(a_ch) == ch) begin
                case (a_word)
                    2'(WORD_CSR): rdata = csr_pack(csr_q[ch], calout[ch]);
                    2'(WORD_NRM): rdata = trim_pack(usr_nrm[ch]);
                    2'(WORD_LP):  rdata = trim_pack(usr_lp[ch]);
                    default:      rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/amp_ctrl_regs_chk.sv
module amp_ctrl_regs_chk
    import amp_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [NCH-1:0]        chan_en,
    input logic [NCH-1:0]        lp_en,
    input logic [NCH-1:0]        out_en,
    input logic [NCH-1:0]        cal_iso,
    input logic [NCH-1:0]        vinp_pin_sw,
    input logic [NCH-1:0]        vinp_dac_sw,
    input logic [NCH-1:0]        vinm_pin_sw,
    input logic [NCH-1:0]        follow_sw,
    input logic [NCH*NTAP-1:0]   pga_tap,
    input logic [NCH*TRIM_W-1:0] trim_n_out,
    input logic [NCH*TRIM_W-1:0] trim_p_out
);
    logic bad_addr;

    assign bad_addr = (addr[1:0] != 2'b00) || (addr[3:2] == 2'd3) ||
                      (int'(addr[ADDR_W-1:4]) >= NCH);

    // R3: a write to an unmapped address leaves every decoded output untouched
    assert_unmapped_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bad_addr) |=> ($stable(out_en) && $stable(lp_en) && $stable(pga_tap) &&
                                 $stable(vinm_pin_sw) && $stable(trim_n_out) && $stable(trim_p_out)))
        else $error("unmapped write changed outputs");

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R4: the output driver never runs on a disabled channel
        assert_out_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
            out_en[c] |-> chan_en[c])
            else $error("out_en without enable");

        // R5: the noninverting input never sees both sources
        assert_vinp_excl_R5: assert property (@(posedge clk) disable iff (rst)
            !(vinp_pin_sw[c] && vinp_dac_sw[c]))
            else $error("both noninverting switches closed");

        // R7: at most one gain tap, and never together with follower feedback
        assert_tap_onehot_R7: assert property (@(posedge clk) disable iff (rst)
            $onehot0(pga_tap[c*NTAP +: NTAP]) && !(follow_sw[c] && (pga_tap[c*NTAP +: NTAP] != '0)))
            else $error("gain tap conflict");

        // R8: calibration opens every path
        assert_cal_open_R8: assert property (@(posedge clk) disable iff (rst)
            cal_iso[c] |-> (!out_en[c] && !vinp_pin_sw[c] && !vinp_dac_sw[c] &&
                            !vinm_pin_sw[c] && !follow_sw[c] && (pga_tap[c*NTAP +: NTAP] == '0)))
            else $error("switch closed during calibration");

        // R10: the low-power bit holds while the channel is enabled
        assert_lp_lock_R10: assert property (@(posedge clk) disable iff (rst)
            chan_en[c] |=> $stable(lp_en[c]))
            else $error("low-power bit changed while enabled");
    end
endmodule

bind amp_ctrl_regs amp_ctrl_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .chan_en     (chan_en),
    .lp_en       (lp_en),
    .out_en      (out_en),
    .cal_iso     (cal_iso),
    .vinp_pin_sw (vinp_pin_sw),
    .vinp_dac_sw (vinp_dac_sw),
    .vinm_pin_sw (vinm_pin_sw),
    .follow_sw   (follow_sw),
    .pga_tap     (pga_tap),
    .trim_n_out  (trim_n_out),
    .trim_p_out  (trim_p_out)
);

// File: tb/amp_ctrl_regs_test.sv
module amp_ctrl_regs_test;
    localparam int NCH = 2;
    localparam int AW  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [19:0]     fact_trim_nrm;
    logic [19:0]     fact_trim_lp;
    logic [1:0]      cmp_async = '0;
    logic [1:0]      vinp_pin_sw, vinp_dac_sw, vinm_pin_sw, follow_sw;
    logic [7:0]      pga_tap;
    logic [1:0]      out_en, cal_iso, cal_psel, lp_en, hs_en;
    logic            range_en;
    logic [9:0]      trim_n_out, trim_p_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // factory codes {P,N}: ch0 nrm 0A/03, ch1 nrm 11/1E, ch0 lp 07/19, ch1 lp 02/0C
    assign fact_trim_nrm = {5'h11, 5'h1E, 5'h0A, 5'h03};
    assign fact_trim_lp  = {5'h02, 5'h0C, 5'h07, 5'h19};

    always #10 clk = ~clk;

    amp_ctrl_regs #(.NCH(NCH), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .fact_trim_nrm(fact_trim_nrm), .fact_trim_lp(fact_trim_lp), .cmp_async(cmp_async),
        .vinp_pin_sw(vinp_pin_sw), .vinp_dac_sw(vinp_dac_sw), .vinm_pin_sw(vinm_pin_sw),
        .follow_sw(follow_sw), .pga_tap(pga_tap), .out_en(out_en), .cal_iso(cal_iso),
        .cal_psel(cal_psel), .lp_en(lp_en), .hs_en(hs_en), .range_en(range_en),
        .trim_n_out(trim_n_out), .trim_p_out(trim_p_out)
    );

    // control word for ch0, expected {vinp_pin,vinp_dac,vinm_pin,follow,tap[3:0],out_en,cal_iso}
    localparam logic [41:0] VEC [12] = '{
        {32'h0000_0001, 10'b1010000010},
        {32'h0000_0401, 10'b0110000010},
        {32'h0000_0201, 10'b1000000010},
        {32'h0000_020D, 10'b1001000010},
        {32'h0000_000D, 10'b1001000010},
        {32'h0000_0009, 10'b1010000110},
        {32'h0000_0019, 10'b1010001010},
        {32'h0000_0229, 10'b1000010010},
        {32'h0000_0039, 10'b1010100010},
        {32'h0000_1001, 10'b0000000001},
        {32'h0000_0408, 10'b0000000000},
        {32'h0000_1000, 10'b0000000000}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rdchk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rdchk("R1 ctl0", 8'h00, 32'h0);
        rdchk("R1 ctl1", 8'h10, 32'h0);
        rdchk("R1 nrm0", 8'h04, 32'h0000_0A03);
        rdchk("R1 lp0",  8'h08, 32'h0000_0719);
        rdchk("R1 nrm1", 8'h14, 32'h0000_111E);
        rdchk("R1 lp1",  8'h18, 32'h0000_020C);
        check("R1 applied trim ch0", {22'b0, trim_p_out[4:0], trim_n_out[4:0]}, {22'b0, 5'h0A, 5'h03});
        check("R1 out_en", {30'b0, out_en}, 32'h0);

        // R4 R5 R6 R7 R8 decode table on ch0
        for (int i = 0; i < 12; i++) begin
            wr(8'h00, VEC[i][41:10]);
            #1;
            check($sformatf("R4-decode vec%0d (R5 R6 R7 R8)", i),
                  {22'b0, vinp_pin_sw[0], vinp_dac_sw[0], vinm_pin_sw[0], follow_sw[0],
                   pga_tap[3:0], out_en[0], cal_iso[0]},
                  {22'b0, VEC[i][9:0]});
            rdchk($sformatf("R2 readback vec%0d", i), 8'h00, VEC[i][41:10]);
        end

        // R8 calibration pair select
        wr(8'h00, 32'h0000_3001);
        #1;
        check("R8 cal_psel", {31'b0, cal_psel[0]}, 32'h1);

        // R2 reserved bits, range bit only on ch1 word
        wr(8'h10, 32'hFFFF_FFFF);
        rdchk("R2 ctl1 mask", 8'h10, 32'h4000_763F);
        check("R2 hs_en lp_en ch1", {30'b0, hs_en[1], lp_en[1]}, 32'h3);
        check("R2 range from ch2 word", {31'b0, range_en}, 32'h0);
        wr(8'h00, 32'h8000_0000);
        rdchk("R2 range readback", 8'h00, 32'h8000_0000);
        check("R2 range_en set", {31'b0, range_en}, 32'h1);
        wr(8'h00, 32'h0);
        check("R2 range_en clear", {31'b0, range_en}, 32'h0);

        // R10 ch1 enabled with lp=1: clearing write keeps lp
        wr(8'h10, 32'h0);
        rdchk("R10 ch1 lp kept on disable write", 8'h10, 32'h0000_0002);
        wr(8'h10, 32'h0);
        rdchk("R10 ch1 lp clears when disabled", 8'h10, 32'h0);

        // R3 unmapped addresses
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rdchk("R3 read 0x0C", 8'h0C, 32'h0);
        rdchk("R3 read 0x1C", 8'h1C, 32'h0);
        rdchk("R3 read 0x20", 8'h20, 32'h0);
        rdchk("R3 ctl0 untouched", 8'h00, 32'h0);
        rdchk("R3 nrm0 untouched", 8'h04, 32'h0000_0A03);
        check("R3 out_en untouched", {30'b0, out_en}, 32'h0);

        // R9 trim selection
        wr(8'h04, 32'hFFFF_F5E6);
        wr(8'h08, 32'h0000_0B1F);
        rdchk("R9 nrm0 masked", 8'h04, 32'h0000_1506);
        check("R9 factory while user=0", {22'b0, trim_p_out[4:0], trim_n_out[4:0]}, {22'b0, 5'h0A, 5'h03});
        wr(8'h00, 32'h0000_4000);
        check("R9 user normal", {22'b0, trim_p_out[4:0], trim_n_out[4:0]}, {22'b0, 5'h15, 5'h06});
        wr(8'h00, 32'h0000_4002);
        check("R9 user low-power", {22'b0, trim_p_out[4:0], trim_n_out[4:0]}, {22'b0, 5'h0B, 5'h1F});
        wr(8'h00, 32'h0000_0002);
        check("R9 factory low-power", {22'b0, trim_p_out[4:0], trim_n_out[4:0]}, {22'b0, 5'h07, 5'h19});
        check("R9 ch1 factory normal", {22'b0, trim_p_out[9:5], trim_n_out[9:5]}, {22'b0, 5'h11, 5'h1E});

        // R10 lock while enabled, other fields applied in the same write
        wr(8'h00, 32'h0000_0003);
        wr(8'h00, 32'h0000_0009);
        rdchk("R10 lp held mode applied", 8'h00, 32'h0000_000B);
        check("R10 lp_en", {31'b0, lp_en[0]}, 32'h1);
        check("R10 tap applied", {28'b0, pga_tap[3:0]}, 32'h1);
        wr(8'h00, 32'h0);
        rdchk("R10 lp held on disable", 8'h00, 32'h0000_0002);
        wr(8'h00, 32'h0);
        rdchk("R10 lp cleared", 8'h00, 32'h0);
        rdchk("R10 trim retained", 8'h04, 32'h0000_1506);

        // R11 comparator synchronizer
        wr(8'h00, 32'h0000_1001);
        cmp_async[0] = 1'b1;
        @(negedge clk);
        rdchk("R11 one edge", 8'h00, 32'h0000_1001);
        @(negedge clk);
        rdchk("R11 two edges", 8'h00, 32'h0000_9001);
        wr(8'h00, 32'h0000_8001);
        rdchk("R11 cal off reads 0", 8'h00, 32'h0000_0001);
        rd(8'h10, v);
        check("R11 ch1 unaffected", v, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule